// File: doc/BRIEF.md
# SMBus Clock-Stretch and Lock-Up Guard

This block sits beside the byte engine of an SMBus/PMBus target and handles the timing duties of that target. It takes both bus lines through a synchronizer and finds START and STOP conditions. It counts the clock pulses of each byte. When the core logic asks for time, the block holds the clock line low. The target only ever acts as a responder: it never drives a clock edge of its own. It may only keep SCL low after the master has already pulled it low.

A stretch may begin only at two points: just after START, or just after the falling clock edge that ends the acknowledge (ninth) pulse. A stretch has a hard ceiling of `STRETCH_MAX_MS` ticks of a 1 ms timebase. A separate watchdog counts how long either line stays low. If that time passes `STUCK_MAX_MS`, the block sends a one-cycle abort pulse to the transaction logic and lets go of both lines. It then ignores the bus until it sees a STOP or a stretch of bus idle. Timing comes from the tick input and does not depend on the clock rate, so buses running at 10 kHz to 400 kHz are all handled the same way.

Top module: `smbus_stretch_guard`

## Requirements
- R1: After reset, sclPullDown, sdaPullDown and abortPulse are all 0.
- R2: If busyReq is high after the falling SCL edge that ends the ninth clock pulse of a byte, sclPullDown rises and stays high while busyReq stays high. It falls within a few cycles after busyReq drops.
- R3: After a START (SDA falling while SCL is high), a busyReq seen once the master has pulled SCL low also stretches the clock. It is released the same way as in R2.
- R4: busyReq has no effect on sclPullDown at any other point: not after the falling edge of clock pulses 1 to 8, and not in the idle state.
- R5: A stretch ends on the `STRETCH_MAX_MS`-th msTick counted during it, even if busyReq is still high. The clock is not held again until the next permitted point.
- R6: abortPulse is high for exactly one cycle, on the (`STUCK_MAX_MS`+1)-th msTick seen while SCL or SDA is low. The tick count starts again whenever both lines are seen high.
- R7: After an abort, sclPullDown and sdaPullDown stay 0 whatever busyReq and sdaDriveReq do. This holds until a STOP is seen, or until both lines have been high for `IDLE_CLKS` consecutive clock cycles.
- R8: When not aborted, sdaPullDown follows sdaDriveReq.
- R9: A START, including a repeated START in the middle of a byte, restarts the clock-pulse count. The next acknowledge pulse is then the ninth pulse after that START.
- R10: sclPullDown only rises when the synchronized SCL is already low, so the block never makes a falling clock edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| busyReq | input | 1 | Core logic asks for a clock stretch |
| sdaDriveReq | input | 1 | Core logic asks to pull SDA low |
| msTick | input | 1 | One-cycle pulse every millisecond |
| sclPullDown | output | 1 | Enable for the SCL open-drain pull-down |
| sdaPullDown | output | 1 | Enable for the SDA open-drain pull-down |
| abortPulse | output | 1 | One-cycle abort notice to the transaction logic |

## Verification
Four properties are checked on every cycle:
- a clock hold only starts on a line that is already low, after busyReq;
- no hold has counted as many ticks as the ceiling;
- an abort pulse lasts one cycle and follows the full stuck-low tick count;
- both pull-downs are off once an abort has happened.

Other behaviour needs whole bus scenarios driven by the bench. That covers whether a stretch is allowed at a given pulse position, the clearing of the pulse count by a repeated START, the way a cap-released stretch stays off, and the two ways out of the aborted state (STOP and idle time). A randomized sequence of bytes, with the busy request placed at random pulse positions, exercises the permitted-point rule against a bench model.

// File: rtl/smbus_guard_pkg.sv
package smbus_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_ABORT = 2'd3
  } guardState_t;

  // Events found by the datapath, consumed by the control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclLow;
    logic ackFall;
    logic capHit;
    logic stuckHit;
    logic busIdle;
  } guardEvt_t;

  // Strobes sent by the control to the datapath
  typedef struct packed {
    logic stretching;
    logic aborted;
  } guardCtl_t;

endpackage

// File: rtl/smbus_guard_datapath.sv
module smbus_guard_datapath
  import smbus_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BITS_PER_BYTE  = 9,
  parameter int STRETCH_MAX_MS = 25,
  parameter int STUCK_MAX_MS   = 35,
  parameter int IDLE_CLKS      = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      msTick,
  input  guardCtl_t ctl,
  output guardEvt_t evt,
  output logic      sclSync,
  output logic      sdaSync
);

  localparam int BIT_W     = $clog2(BITS_PER_BYTE + 1);
  localparam int STRETCH_W = $clog2(STRETCH_MAX_MS + 1);
  localparam int STUCK_W   = $clog2(STUCK_MAX_MS + 1);
  localparam int IDLE_W    = $clog2(IDLE_CLKS + 1);
  localparam int LINES     = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;

  assign lineRaw = {sdaIn, sclIn};

  // One synchronizer chain for each bus line, idle level high
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= '1;
      else        stages <= {stages[SYNC_STAGES-2:0], lineRaw[g]};
    end
    assign lineSync[g] = stages[SYNC_STAGES-1];
  end

  assign sclSync = lineSync[0];
  assign sdaSync = lineSync[1];

  logic sclPrev, sdaPrev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  logic sclRise, sclFall, startSeen, stopSeen, bothHigh;
  assign sclRise   = sclSync & ~sclPrev;
  assign sclFall   = ~sclSync & sclPrev;
  assign startSeen = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopSeen  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign bothHigh  = sclSync & sdaSync;

  // Clock-pulse position inside the current byte (counts rising edges)
  logic [BIT_W-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulseCnt <= '0;
    else if (startSeen || ctl.aborted) pulseCnt <= '0;
    else if (sclRise) begin
      if (pulseCnt == BIT_W'(BITS_PER_BYTE)) pulseCnt <= BIT_W'(1);
      else                                   pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // Ticks spent inside the current stretch
  logic [STRETCH_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdCnt <= '0;
    else if (!ctl.stretching) holdCnt <= '0;
    else if (msTick && holdCnt != STRETCH_W'(STRETCH_MAX_MS)) holdCnt <= holdCnt + 1'b1;
  end

  // Ticks with a line low, cleared by both lines high
  logic [STUCK_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowCnt <= '0;
    else if (ctl.aborted || bothHigh) lowCnt <= '0;
    else if (msTick && lowCnt != STUCK_W'(STUCK_MAX_MS)) lowCnt <= lowCnt + 1'b1;
  end

  // Consecutive cycles with both lines high
  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idleCnt <= '0;
    else if (!bothHigh) idleCnt <= '0;
    else if (idleCnt != IDLE_W'(IDLE_CLKS)) idleCnt <= idleCnt + 1'b1;
  end

  always_comb begin
    evt           = '0;
    evt.startSeen = startSeen;
    evt.stopSeen  = stopSeen;
    evt.sclRise   = sclRise;
    evt.sclLow    = ~sclSync;
    evt.ackFall   = sclFall && (pulseCnt == BIT_W'(BITS_PER_BYTE));
    evt.capHit    = ctl.stretching && msTick && (holdCnt == STRETCH_W'(STRETCH_MAX_MS - 1));
    evt.stuckHit  = !ctl.aborted && !bothHigh && msTick && (lowCnt == STUCK_W'(STUCK_MAX_MS));
    evt.busIdle   = (idleCnt == IDLE_W'(IDLE_CLKS));
  end

endmodule

// File: rtl/smbus_guard_control.sv
module smbus_guard_control
  import smbus_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  guardEvt_t evt,
  input  logic      busyReq,
  input  logic      sdaDriveReq,
  output guardCtl_t ctl,
  output logic      sclPullDown,
  output logic      sdaPullDown,
  output logic      abortPulse
);

  guardState_t state, stateNext;
  logic        stretchOk, stretchOkNext;
  logic        abortNext;

  always_comb begin
    stateNext     = state;
    stretchOkNext = stretchOk;
    abortNext     = 1'b0;
    if (evt.stuckHit && state != ST_ABORT) begin
      stateNext     = ST_ABORT;
      stretchOkNext = 1'b0;
      abortNext     = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (evt.startSeen) begin
            stateNext     = ST_XFER;
            stretchOkNext = 1'b1;
          end
        end
        ST_XFER: begin
          if (evt.stopSeen) begin
            stateNext     = ST_IDLE;
            stretchOkNext = 1'b0;
          end else if (evt.startSeen) begin
            stretchOkNext = 1'b1;
          end else if (evt.sclRise) begin
            stretchOkNext = 1'b0;
          end else if ((stretchOk || evt.ackFall) && evt.sclLow && busyReq) begin
            stateNext     = ST_HOLD;
            stretchOkNext = 1'b1;
          end else if (evt.ackFall) begin
            stretchOkNext = 1'b1;
          end
        end
        ST_HOLD: begin
          if (evt.capHit || !busyReq) begin
            stateNext     = ST_XFER;
            stretchOkNext = 1'b0;
          end
        end
        ST_ABORT: begin
          stretchOkNext = 1'b0;
          if (evt.stopSeen || evt.busIdle) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      stretchOk  <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      stretchOk  <= stretchOkNext;
      abortPulse <= abortNext;
    end
  end

  assign ctl.stretching = (state == ST_HOLD);
  assign ctl.aborted    = (state == ST_ABORT);
  assign sclPullDown    = (state == ST_HOLD);
  assign sdaPullDown    = sdaDriveReq && (state != ST_ABORT);

endmodule

// File: rtl/smbus_stretch_guard.sv
module smbus_stretch_guard
  import smbus_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BITS_PER_BYTE  = 9,
  parameter int STRETCH_MAX_MS = 25,
  parameter int STUCK_MAX_MS   = 35,
  parameter int IDLE_CLKS      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic busyReq,
  input  logic sdaDriveReq,
  input  logic msTick,
  output logic sclPullDown,
  output logic sdaPullDown,
  output logic abortPulse
);

  guardEvt_t evt;
  guardCtl_t ctl;
  logic      sclSync, sdaSync;

  smbus_guard_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .BITS_PER_BYTE (BITS_PER_BYTE),
    .STRETCH_MAX_MS(STRETCH_MAX_MS),
    .STUCK_MAX_MS  (STUCK_MAX_MS),
    .IDLE_CLKS     (IDLE_CLKS)
  ) uPath (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .msTick (msTick),
    .ctl    (ctl),
    .evt    (evt),
    .sclSync(sclSync),
    .sdaSync(sdaSync)
  );

  smbus_guard_control uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .busyReq    (busyReq),
    .sdaDriveReq(sdaDriveReq),
    .ctl        (ctl),
    .sclPullDown(sclPullDown),
    .sdaPullDown(sdaPullDown),
    .abortPulse (abortPulse)
  );

endmodule

// File: rtl/smbus_guard_checker.sv
module smbus_guard_checker #(
  parameter int STRETCH_MAX_MS = 25,
  parameter int STUCK_MAX_MS   = 35
) (
  input logic clk,
  input logic rst_n,
  input logic sclSync,
  input logic sdaSync,
  input logic busyReq,
  input logic msTick,
  input logic sclPullDown,
  input logic sdaPullDown,
  input logic abortPulse
);

  localparam int HOLD_W = $clog2(STRETCH_MAX_MS + 2);
  localparam int LOW_W  = $clog2(STUCK_MAX_MS + 2);

  logic [HOLD_W-1:0] holdTicks;
  logic [LOW_W-1:0]  lowTicks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdTicks <= '0;
    else if (!sclPullDown) holdTicks <= '0;
    else if (msTick && holdTicks != HOLD_W'(STRETCH_MAX_MS + 1)) holdTicks <= holdTicks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowTicks <= '0;
    else if (sclSync && sdaSync) lowTicks <= '0;
    else if (msTick && lowTicks != LOW_W'(STUCK_MAX_MS + 1)) lowTicks <= lowTicks + 1'b1;
  end

  // R10: a hold only begins on a line already low, R2: and only on request
  a_r10_hold_on_low_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclPullDown) |-> (!$past(sclSync) && $past(busyReq)));

  // R5: a hold never survives its tick ceiling
  a_r5_hold_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    sclPullDown |-> (holdTicks < HOLD_W'(STRETCH_MAX_MS)));

  // R6: abort lasts one cycle
  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |=> !abortPulse);

  // R6: abort only after the full stuck-low count
  a_r6_abort_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |-> (lowTicks == LOW_W'(STUCK_MAX_MS + 1)));

  // R7: both lines are let go once aborted
  a_r7_release_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |-> (!sclPullDown && !sdaPullDown));

endmodule

bind smbus_stretch_guard smbus_guard_checker #(
  .STRETCH_MAX_MS(STRETCH_MAX_MS),
  .STUCK_MAX_MS  (STUCK_MAX_MS)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclSync    (sclSync),
  .sdaSync    (sdaSync),
  .busyReq    (busyReq),
  .msTick     (msTick),
  .sclPullDown(sclPullDown),
  .sdaPullDown(sdaPullDown),
  .abortPulse (abortPulse)
);

// File: tb/smbus_stretch_guard_test.sv
`timescale 1ns/1ps
module smbus_stretch_guard_test;

  localparam int CAP_MS   = 25;
  localparam int STUCK_MS = 35;
  localparam int IDLE_CK  = 64;
  localparam int ACK_POS  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic busyReq = 1'b0, sdaDriveReq = 1'b0, msTick = 1'b0;
  logic sclPullDown, sdaPullDown, abortPulse;
  logic sclBus, sdaBus;

  int checks = 0;
  int failures = 0;
  int abortCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sclBus = sclM & ~sclPullDown;
  assign sdaBus = sdaM & ~sdaPullDown;

  smbus_stretch_guard uut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclBus), .sdaIn(sdaBus),
    .busyReq(busyReq), .sdaDriveReq(sdaDriveReq), .msTick(msTick),
    .sclPullDown(sclPullDown), .sdaPullDown(sdaPullDown), .abortPulse(abortPulse)
  );

  always @(posedge clk) if (rst_n && abortPulse) abortCount <= abortCount + 1;

  function automatic bit expectHold(input int pos);
    return pos == ACK_POS;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1; waitc(1); msTick = 1'b0; waitc(2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitc(10);
    sdaM = 1'b0; waitc(10);
    sclM = 1'b0; waitc(10);
  endtask

  task automatic stopCond();
    sclM = 1'b0; waitc(5); sdaM = 1'b0; waitc(5);
    sclM = 1'b1; while (!sclBus) waitc(1);
    waitc(10); sdaM = 1'b1; waitc(10);
  endtask

  task automatic repStart();
    sclM = 1'b0; waitc(5); sdaM = 1'b1; waitc(5);
    sclM = 1'b1; waitc(10); sdaM = 1'b0; waitc(10);
    sclM = 1'b0; waitc(10);
  endtask

  task automatic clockBit(input logic v);
    sdaM = v; waitc(5);
    sclM = 1'b1; while (!sclBus) waitc(1);
    waitc(10); sclM = 1'b0; waitc(10);
  endtask

  // eight data pulses then an acknowledge pulse; busy asked after pulse busyAt
  task automatic byteBusy(input logic [7:0] data, input int busyAt, input string req);
    for (int b = 1; b <= ACK_POS; b++) begin
      clockBit(b == ACK_POS ? 1'b0 : data[8-b]);
      if (b == busyAt) begin
        busyReq = 1'b1; waitc(8);
        chk(req, int'(sclPullDown), int'(expectHold(b)));
        busyReq = 1'b0; waitc(8);
        chk(req, int'(sclPullDown), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h1c2b3a49));
    waitc(4);
    // R1: reset values
    chk("R1 sclPullDown", int'(sclPullDown), 0);
    chk("R1 sdaPullDown", int'(sdaPullDown), 0);
    chk("R1 abortPulse", int'(abortPulse), 0);
    rst_n = 1'b1; waitc(5);

    // R4: no stretch while idle
    busyReq = 1'b1; sclM = 1'b0; waitc(10);
    chk("R4 idle no hold", int'(sclPullDown), 0);
    busyReq = 1'b0; sclM = 1'b1; waitc(10);

    // R3: stretch right after START
    sdaM = 1'b0; waitc(10);
    busyReq = 1'b1; sclM = 1'b0; waitc(8);
    chk("R3 hold after start", int'(sclPullDown), 1);
    busyReq = 1'b0; waitc(6);
    chk("R3 release", int'(sclPullDown), 0);

    // R2 and R4 directed
    byteBusy(8'hA5, 9, "R2 ack hold");
    byteBusy(8'h3C, 4, "R4 mid-byte");
    byteBusy(8'hFF, 8, "R4 pulse8");
    stopCond();

    // R2/R4 random positions
    for (int t = 0; t < 12; t++) begin
      startCond();
      for (int k = 0; k < 2; k++)
        byteBusy(8'($urandom), int'($urandom_range(0, 9)), "R4 random position");
      stopCond();
    end

    // R5: ceiling on a stretch
    startCond();
    byteBusy(8'h12, 0, "R5 setup");
    busyReq = 1'b1; waitc(8);
    chk("R5 hold begins", int'(sclPullDown), 1);
    ticks(CAP_MS - 1);
    chk("R5 hold before cap", int'(sclPullDown), 1);
    tick(); waitc(2);
    chk("R5 released at cap", int'(sclPullDown), 0);
    waitc(20);
    chk("R5 no re-hold", int'(sclPullDown), 0);
    busyReq = 1'b0;
    // R8: data pull-down follows the request
    sdaDriveReq = 1'b1; waitc(5);
    chk("R8 sda follows", int'(sdaPullDown), 1);
    sdaDriveReq = 1'b0; waitc(5);
    chk("R8 sda off", int'(sdaPullDown), 0);
    stopCond();

    // R6: stuck-low abort, counter cleared by both lines high
    startCond();
    byteBusy(8'h55, 0, "R6 setup");
    sdaM = 1'b1; waitc(5);
    base = abortCount;
    ticks(30);
    sclM = 1'b1; waitc(10); sclM = 1'b0; waitc(10);
    ticks(STUCK_MS);
    chk("R6 no abort before limit", abortCount - base, 0);
    tick(); waitc(3);
    chk("R6 abort on limit", abortCount - base, 1);
    waitc(20);
    chk("R6 single pulse", abortCount - base, 1);

    // R7: ignored while aborted, left by STOP
    busyReq = 1'b1; sdaDriveReq = 1'b1; waitc(10);
    chk("R7 scl released", int'(sclPullDown), 0);
    chk("R7 sda released", int'(sdaPullDown), 0);
    for (int b = 0; b < ACK_POS; b++) clockBit(1'b0);
    waitc(4);
    chk("R7 no hold after ack", int'(sclPullDown), 0);
    busyReq = 1'b0; sdaDriveReq = 1'b0;
    stopCond();
    sdaDriveReq = 1'b1; waitc(6);
    chk("R7 stop exits abort", int'(sdaPullDown), 1);
    sdaDriveReq = 1'b0; waitc(20);

    // R7: left by bus idle time
    sdaM = 1'b1; sclM = 1'b0; waitc(5);
    base = abortCount;
    ticks(STUCK_MS + 1); waitc(3);
    chk("R6 abort outside transfer", abortCount - base, 1);
    sdaDriveReq = 1'b1; sclM = 1'b1; waitc(IDLE_CK / 2);
    chk("R7 still aborted", int'(sdaPullDown), 0);
    waitc(IDLE_CK);
    chk("R7 idle exits abort", int'(sdaPullDown), 1);
    sdaDriveReq = 1'b0; waitc(20);

    // R9: repeated START restarts the pulse count
    startCond();
    for (int b = 0; b < 4; b++) clockBit(1'b1);
    repStart();
    byteBusy(8'h81, 5, "R9 old ack position");
    waitc(2);
    stopCond();
    startCond();
    for (int b = 0; b < 4; b++) clockBit(1'b1);
    repStart();
    byteBusy(8'h81, 9, "R9 ack after restart");
    stopCond();

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule